// File: doc/BRIEF.md
# Byte-Wide Data Space with Pointer Redirection

This block is the data-side storage map of a small 8-bit core. A 6-bit address space of 64 byte locations is split into a low half of special-function registers and a high half of 32 bytes of general-purpose RAM. The core drives one read address and one write operation per cycle. The write operation is a full byte store, a single-bit set or a single-bit clear. Location 00H holds no data. Every access made at that address is redirected to the location named by a 6-bit pointer register at 01H.

The accumulator, low program-counter byte, table pointer, status and the three port latches are driven out as plain register outputs, so the ALU, sequencer and pin logic can use them directly. The table high byte cannot be written through the data port. It is filled only through a dedicated load input used by the table-read sequence. Each port latch also has a one-cycle update strobe. Addresses below 20H that carry no register read back as zero and ignore writes.

Top module: `data_space`

## Requirements
- R1: A byte write (`wr_op` = 2'b01) to any writable location (01H, 05H, 06H, 07H, 0AH, 12H, 14H, 16H, 20H..3FH) is returned by a later read of that address.
- R2: A read or write at address 00H acts on the location whose address is held in the pointer register, with the same rules as a direct access to that location.
- R3: When the pointer holds 00H, a read through 00H returns 00H and any write operation through 00H changes nothing.
- R4: The pointer keeps only bits 5..0 of written data, and reads of 01H return ones in bits 7..6.
- R5: Accumulator (05H), PCL (06H), table pointer (07H), status (0AH) and port latches A/B/C (12H/14H/16H) appear on their output ports one cycle after the write edge.
- R6: Addresses 02H-04H, 09H, 0BH-11H, 13H, 15H, 17H-1FH read as 00H, and writes to them have no effect.
- R7: `wr_op` = 2'b10 sets and 2'b11 clears bit `wr_bit` (0 = LSB) of the addressed location, leaving the other bits unchanged; 2'b00 is idle.
- R8: The table high byte at 08H ignores every data-port write and takes `tbl_ld_data` on any edge with `tbl_ld` high.
- R9: Synchronous reset clears all storage, register outputs, strobes and `rd_data`; afterwards 01H reads C0H.
- R10: `rd_data` is registered: it shows, one cycle after `rd_addr` is sampled, the location's value before any write in that same edge.
- R11: `port_stb` bit 0/1/2 pulses for one cycle, together with the new value, after any write operation lands on port A/B/C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Registered read data |
| wr_op | input | 2 | 00 idle, 01 byte write, 10 bit set, 11 bit clear |
| wr_addr | input | 6 | Write-operation address |
| wr_bit | input | 3 | Bit index for set/clear |
| wr_data | input | 8 | Byte write data |
| tbl_ld | input | 1 | Load strobe for the table high byte |
| tbl_ld_data | input | 8 | Table high byte load value |
| acc_q | output | 8 | Accumulator |
| pcl_q | output | 8 | Low program-counter byte |
| tblp_q | output | 8 | Table pointer |
| status_q | output | 8 | Status register |
| porta_q | output | 8 | Port A latch |
| portb_q | output | 8 | Port B latch |
| portc_q | output | 8 | Port C latch |
| port_stb | output | 3 | Port latch update strobes (bit 0 = A) |

## Verification
Every result of this block is due exactly one edge after its stimulus. Read data, register outputs and port strobes all appear together after the edge that samples the inputs, and a read in the same edge as a write still shows the old value. The bench drives inputs just after a falling edge. At that moment it computes the expected read value from its model state before the write, then updates the model. It compares all outputs at the next falling edge, so each comparison falls half a period after the single register stage it depends on.

// File: rtl/data_space_pkg.sv
package data_space_pkg;
  localparam int DW_DEF = 8;
  localparam int AW_DEF = 6;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_BSET  = 2'b10,
    OP_BCLR  = 2'b11
  } wr_op_e;

  // fixed register locations (behavioural: the core decodes them)
  localparam int LOC_IND  = 'h00;
  localparam int LOC_PTR  = 'h01;
  localparam int LOC_ACC  = 'h05;
  localparam int LOC_PCL  = 'h06;
  localparam int LOC_TBLP = 'h07;
  localparam int LOC_TBLH = 'h08;
  localparam int LOC_STAT = 'h0A;
  localparam int LOC_PRTA = 'h12;
  localparam int LOC_PRTB = 'h14;
  localparam int LOC_PRTC = 'h16;
endpackage

// File: rtl/ds_addr_resolve.sv
module ds_addr_resolve #(
  parameter int AW = 6
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ptr,
  output logic [AW-1:0] eff,
  output logic          null_sel
);
  always_comb begin
    eff      = (addr == '0) ? ptr : addr;
    null_sel = (eff == '0);
  end
endmodule

// File: rtl/ds_gp_ram.sv
module ds_gp_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr0,
  output logic [DW-1:0] rdata0,
  input  logic [IW-1:0] raddr1,
  output logic [DW-1:0] rdata1
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];
endmodule

// File: rtl/ds_sfr_bank.sv
module ds_sfr_bank
  import data_space_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          tbl_ld,
  input  logic [DW-1:0] tbl_ld_data,
  input  logic [AW-1:0] raddr0,
  output logic [DW-1:0] rdata0,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rdata1,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] acc_q,
  output logic [DW-1:0] pcl_q,
  output logic [DW-1:0] tblp_q,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] porta_q,
  output logic [DW-1:0] portb_q,
  output logic [DW-1:0] portc_q,
  output logic [2:0]    port_stb
);
  localparam logic [AW-1:0] A_PTR  = AW'(LOC_PTR);
  localparam logic [AW-1:0] A_ACC  = AW'(LOC_ACC);
  localparam logic [AW-1:0] A_PCL  = AW'(LOC_PCL);
  localparam logic [AW-1:0] A_TBLP = AW'(LOC_TBLP);
  localparam logic [AW-1:0] A_TBLH = AW'(LOC_TBLH);
  localparam logic [AW-1:0] A_STAT = AW'(LOC_STAT);
  localparam logic [AW-1:0] A_PRTA = AW'(LOC_PRTA);
  localparam logic [AW-1:0] A_PRTB = AW'(LOC_PRTB);
  localparam logic [AW-1:0] A_PRTC = AW'(LOC_PRTC);
  localparam int PAD = DW - AW;

  logic [AW-1:0] mp_q;
  logic [DW-1:0] tblh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mp_q     <= '0;
      acc_q    <= '0;
      pcl_q    <= '0;
      tblp_q   <= '0;
      tblh_q   <= '0;
      status_q <= '0;
      porta_q  <= '0;
      portb_q  <= '0;
      portc_q  <= '0;
      port_stb <= '0;
    end else begin
      port_stb <= {we && (waddr == A_PRTC),
                   we && (waddr == A_PRTB),
                   we && (waddr == A_PRTA)};
      if (tbl_ld) tblh_q <= tbl_ld_data;
      if (we) begin
        unique case (waddr)
          A_PTR:   mp_q     <= wdata[AW-1:0];
          A_ACC:   acc_q    <= wdata;
          A_PCL:   pcl_q    <= wdata;
          A_TBLP:  tblp_q   <= wdata;
          A_STAT:  status_q <= wdata;
          A_PRTA:  porta_q  <= wdata;
          A_PRTB:  portb_q  <= wdata;
          A_PRTC:  portc_q  <= wdata;
          default: ;  // read-only or unassigned
        endcase
      end
    end
  end

  function automatic logic [DW-1:0] pick(input logic [AW-1:0] a);
    case (a)
      A_PTR:   pick = {{PAD{1'b1}}, mp_q};
      A_ACC:   pick = acc_q;
      A_PCL:   pick = pcl_q;
      A_TBLP:  pick = tblp_q;
      A_TBLH:  pick = tblh_q;
      A_STAT:  pick = status_q;
      A_PRTA:  pick = porta_q;
      A_PRTB:  pick = portb_q;
      A_PRTC:  pick = portc_q;
      default: pick = '0;
    endcase
  endfunction

  assign rdata0 = pick(raddr0);
  assign rdata1 = pick(raddr1);
  assign ptr    = mp_q;
endmodule

// File: rtl/data_space.sv
module data_space
  import data_space_pkg::*;
#(
  parameter int DATA_W = DW_DEF,
  parameter int ADDR_W = AW_DEF,
  localparam int BIT_W = $clog2(DATA_W),
  localparam int GP_DEPTH = 2 ** (ADDR_W - 1),
  localparam int GP_IW = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        wr_op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BIT_W-1:0]  wr_bit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tbl_ld,
  input  logic [DATA_W-1:0] tbl_ld_data,
  output logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] pcl_q,
  output logic [DATA_W-1:0] tblp_q,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] porta_q,
  output logic [DATA_W-1:0] portb_q,
  output logic [DATA_W-1:0] portc_q,
  output logic [2:0]        port_stb
);
  logic [ADDR_W-1:0] ptr, ea_r, ea_w;
  logic              null_r, null_w;
  logic [DATA_W-1:0] ram_r, ram_w, sfr_r, sfr_w;
  logic [DATA_W-1:0] cur_w, rd_val, new_val, mask;
  logic              do_wr, ram_we, sfr_we;
  wr_op_e            op;

  ds_addr_resolve #(.AW(ADDR_W)) u_res_rd (
    .addr(rd_addr), .ptr(ptr), .eff(ea_r), .null_sel(null_r));
  ds_addr_resolve #(.AW(ADDR_W)) u_res_wr (
    .addr(wr_addr), .ptr(ptr), .eff(ea_w), .null_sel(null_w));

  // the effective address's top bit selects the RAM half
  assign rd_val = null_r ? '0 : (ea_r[ADDR_W-1] ? ram_r : sfr_r);
  assign cur_w  = null_w ? '0 : (ea_w[ADDR_W-1] ? ram_w : sfr_w);

  assign op   = wr_op_e'(wr_op);
  assign mask = DATA_W'(1) << wr_bit;

  always_comb begin
    unique case (op)
      OP_WRITE: new_val = wr_data;
      OP_BSET:  new_val = cur_w | mask;
      OP_BCLR:  new_val = cur_w & ~mask;
      default:  new_val = cur_w;
    endcase
  end

  assign do_wr  = (op != OP_IDLE) && !null_w;
  assign ram_we = do_wr && ea_w[ADDR_W-1];
  assign sfr_we = do_wr && !ea_w[ADDR_W-1];

  ds_gp_ram #(.DW(DATA_W), .DEPTH(GP_DEPTH)) u_ram (
    .clk(clk), .rst(rst), .we(ram_we), .waddr(ea_w[GP_IW-1:0]),
    .wdata(new_val),
    .raddr0(ea_r[GP_IW-1:0]), .rdata0(ram_r),
    .raddr1(ea_w[GP_IW-1:0]), .rdata1(ram_w));

  ds_sfr_bank #(.DW(DATA_W), .AW(ADDR_W)) u_sfr (
    .clk(clk), .rst(rst), .we(sfr_we), .waddr(ea_w), .wdata(new_val),
    .tbl_ld(tbl_ld), .tbl_ld_data(tbl_ld_data),
    .raddr0(ea_r), .rdata0(sfr_r), .raddr1(ea_w), .rdata1(sfr_w),
    .ptr(ptr), .acc_q(acc_q), .pcl_q(pcl_q), .tblp_q(tblp_q),
    .status_q(status_q), .porta_q(porta_q), .portb_q(portb_q),
    .portc_q(portc_q), .port_stb(port_stb));

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_val;
  end
endmodule

// File: rtl/data_space_chk.sv
module data_space_chk #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic [1:0]    wr_op,
  input logic          tbl_ld,
  input logic [AW-1:0] mp,
  input logic [DW-1:0] tblh,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] porta_q,
  input logic [2:0]    port_stb
);
  function automatic logic is_hole(input logic [AW-1:0] a);
    is_hole = !a[AW-1] && !(a inside {'h00, 'h01, 'h05, 'h06, 'h07,
                                      'h08, 'h0A, 'h12, 'h14, 'h16});
  endfunction

  p_ptr_ones_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == AW'(1)) |=> (&rd_data[DW-1:AW]));

  p_self_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == '0 && mp == '0) |=> (rd_data == '0));

  p_hole_zero_r6: assert property (@(posedge clk) disable iff (rst)
    is_hole(rd_addr) |=> (rd_data == '0));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_op == 2'b00) |=> ($stable(acc_q) && $stable(porta_q)));

  p_tblh_ro_r8: assert property (@(posedge clk) disable iff (rst)
    !tbl_ld |=> $stable(tblh));

  p_stb_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(port_stb));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && porta_q == '0 && port_stb == '0 && rd_data == '0));
endmodule

bind data_space data_space_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
  .wr_op(wr_op), .tbl_ld(tbl_ld), .mp(u_sfr.mp_q), .tblh(u_sfr.tblh_q),
  .acc_q(acc_q), .porta_q(porta_q), .port_stb(port_stb));

// File: tb/data_space_tb.sv
module data_space_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data, tbl_ld_data;
  logic [1:0] wr_op;
  logic [2:0] wr_bit, port_stb;
  logic       tbl_ld;
  logic [7:0] acc_q, pcl_q, tblp_q, status_q, porta_q, portb_q, portc_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m [64];
  logic [5:0] mp;
  logic [7:0] exp_rd;
  logic [2:0] exp_stb;

  always #4 clk = ~clk;

  data_space u_dut (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_op(wr_op), .wr_addr(wr_addr), .wr_bit(wr_bit), .wr_data(wr_data),
    .tbl_ld(tbl_ld), .tbl_ld_data(tbl_ld_data),
    .acc_q(acc_q), .pcl_q(pcl_q), .tblp_q(tblp_q), .status_q(status_q),
    .porta_q(porta_q), .portb_q(portb_q), .portc_q(portc_q),
    .port_stb(port_stb));

  function automatic bit is_reg(input logic [5:0] a);
    return a inside {6'h05, 6'h06, 6'h07, 6'h08, 6'h0A, 6'h12, 6'h14, 6'h16} || a[5];
  endfunction

  function automatic logic [7:0] mrd(input logic [5:0] a);
    logic [5:0] e;
    e = (a == 0) ? mp : a;
    if (e == 0) return 8'h00;
    if (e == 1) return {2'b11, mp};
    if (is_reg(e)) return m[e];
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    if (a == 0) return "R2";
    if (a == 1) return "R4";
    if (!is_reg(a)) return "R6";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; compares at the next falling edge
  task automatic step(input string tag, input logic [5:0] ra, input logic [1:0] op,
                      input logic [5:0] wa, input logic [2:0] b, input logic [7:0] d,
                      input logic ld, input logic [7:0] ldd);
    logic [5:0] e;
    logic [7:0] cur, v;
    exp_rd  = mrd(ra);
    exp_stb = 3'b000;
    e   = (wa == 0) ? mp : wa;
    cur = mrd(wa);
    case (op)
      2'b01: v = d;
      2'b10: v = cur | (8'h01 << b);
      2'b11: v = cur & ~(8'h01 << b);
      default: v = cur;
    endcase
    if (op != 2'b00 && e != 0) begin
      if (e == 1) mp = v[5:0];
      else if (e != 8 && is_reg(e)) m[e] = v;
      if (e == 6'h12) exp_stb[0] = 1'b1;
      if (e == 6'h14) exp_stb[1] = 1'b1;
      if (e == 6'h16) exp_stb[2] = 1'b1;
    end
    if (ld) m[8] = ldd;
    rd_addr = ra; wr_op = op; wr_addr = wa; wr_bit = b; wr_data = d;
    tbl_ld = ld; tbl_ld_data = ldd;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " rd_data"}, rd_data, exp_rd);
    chk("R5 acc", acc_q, m[5]);
    chk("R5 pcl", pcl_q, m[6]);
    chk("R5 tblp", tblp_q, m[7]);
    chk("R5 status", status_q, m[10]);
    chk("R5 portA", porta_q, m[18]);
    chk("R5 portB", portb_q, m[20]);
    chk("R5 portC", portc_q, m[22]);
    chk("R11 port_stb", {5'b0, port_stb}, {5'b0, exp_stb});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    for (int i = 0; i < 64; i++) m[i] = 8'h00;
    mp = 6'h00;
    rst = 1'b1; rd_addr = 0; wr_op = 0; wr_addr = 0; wr_bit = 0;
    wr_data = 0; tbl_ld = 0; tbl_ld_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: everything cleared, pointer reads C0H
    chk("R9 acc", acc_q, 8'h00);
    chk("R9 portC", portc_q, 8'h00);
    chk("R9 rd_data", rd_data, 8'h00);
    step("R9 ptr", 6'h01, 2'b00, 0, 0, 0, 0, 0);
    chk("R9 ptr C0", rd_data, 8'hC0);
    // R3: self reference through a zero pointer
    step("R3 read", 6'h00, 2'b01, 6'h00, 0, 8'h77, 0, 0);
    step("R3 bitset", 6'h00, 2'b10, 6'h00, 3'd2, 0, 0, 0);
    step("R3 after", 6'h01, 2'b00, 0, 0, 0, 0, 0);
    chk("R3 ptr unchanged", rd_data, 8'hC0);
    // R4: pointer width
    step("R4", 6'h00, 2'b01, 6'h01, 0, 8'hFF, 0, 0);
    step("R4", 6'h01, 2'b01, 6'h01, 0, 8'h55, 0, 0);
    chk("R4 ptr FF", rd_data, 8'hFF);
    step("R4", 6'h01, 2'b00, 0, 0, 0, 0, 0);
    chk("R4 ptr D5", rd_data, 8'hD5);
    // R2: redirected access
    step("R2", 6'h00, 2'b01, 6'h01, 0, 8'h25, 0, 0);
    step("R2", 6'h00, 2'b01, 6'h00, 0, 8'hA5, 0, 0);
    step("R2", 6'h25, 2'b01, 6'h01, 0, 8'h05, 0, 0);
    chk("R2 ind write", rd_data, 8'hA5);
    step("R2", 6'h00, 2'b01, 6'h00, 0, 8'h3C, 0, 0);
    chk("R2 acc via ptr", acc_q, 8'h3C);
    // R6: holes
    step("R6", 6'h00, 2'b01, 6'h0B, 0, 8'h99, 0, 0);
    step("R6", 6'h0B, 2'b00, 0, 0, 0, 0, 0);
    chk("R6 hole", rd_data, 8'h00);
    // R7: bit operations
    step("R7", 6'h00, 2'b10, 6'h21, 3'd7, 0, 0, 0);
    step("R7", 6'h21, 2'b11, 6'h05, 3'd2, 0, 0, 0);
    chk("R7 set b7", rd_data, 8'h80);
    chk("R7 clr b2", acc_q, 8'h38);
    // R8: read-only table high byte
    step("R8", 6'h00, 2'b01, 6'h08, 0, 8'hEE, 0, 0);
    step("R8", 6'h08, 2'b00, 0, 0, 0, 1, 8'h5A);
    chk("R8 write ignored", rd_data, 8'h00);
    step("R8", 6'h08, 2'b10, 6'h08, 3'd0, 0, 0, 0);
    chk("R8 loaded", rd_data, 8'h5A);
    // R10: read-first on same edge
    step("R10", 6'h30, 2'b01, 6'h30, 0, 8'h6B, 0, 0);
    chk("R10 old value", rd_data, 8'h00);
    step("R10", 6'h30, 2'b00, 0, 0, 0, 0, 0);
    chk("R10 new value", rd_data, 8'h6B);
    // R11: port strobe
    step("R11", 6'h14, 2'b01, 6'h14, 0, 8'h11, 0, 0);
    chk("R11 stb B", {5'b0, port_stb}, 8'h02);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] ra, wa;
      ra = ($urandom % 4 == 0) ? 6'h00 : 6'($urandom);
      case ($urandom % 8)
        0, 1: wa = 6'h00;
        2: wa = 6'h01;
        default: wa = 6'($urandom);
      endcase
      step(tag_of(ra), ra, 2'($urandom), wa, 3'($urandom), 8'($urandom),
           ($urandom % 8 == 0), 8'($urandom));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule